// File: doc/BRIEF.md
# Road Window Hit Filter

The block holds a bank of track windows ("roads"). Each road is a closed interval of 11-bit strip positions. A road is written as one word that carries an upper bound and a lower bound, into a slot picked by a select input. When a cluster centroid arrives, it is compared in one cycle against every stored road. The result is a per-road match vector, which the block captures.

A small sequencer then drains that vector one road per cycle. For each matching road it emits a 32-bit hit word that carries the road index and the centroid. While it drains, `busy` is high and new centroids are refused. Roads can be written at any time. A write never changes a vector that has already been captured.

The drain encoder searches the vector in two groups: a low group of 31 roads and a high group of 15 roads. The low group takes precedence. The combined effect is an ascending scan by road index.

Top module: `roadHitFilter`

## Requirements
- R1: After reset, `busy` and `hitValid` are 0 and every slot is empty. A centroid accepted right after reset produces no hit.
- R2: A road word carries its upper bound in bits 21..11 and its lower bound in bits 10..0. A centroid c matches a loaded road exactly when lower <= c <= upper, with both ends inclusive.
- R3: A slot that was never loaded never matches. A loaded road whose lower bound exceeds its upper bound matches no centroid.
- R4: A write with road select 46 or above changes no slot.
- R5: A hit word holds the road index in bits 5..0 and the centroid in bits 16..6. Bits 31..17 are zero.
- R6: Hits of one centroid appear on consecutive cycles in ascending road index, one per cycle. The first hit appears in the cycle after the centroid is accepted.
- R7: `busy` rises in the cycle after acceptance and stays high through the last hit. A centroid with no match keeps `busy` high for exactly one cycle and produces no hit.
- R8: A centroid is accepted only when `centValid` is high while `busy` is low. A centroid presented while `busy` is high is ignored.
- R9: When a road write and a centroid acceptance fall in the same cycle, the comparison uses the slot contents from before the write. The write is seen by later centroids.
- R10: Writing an already loaded slot replaces its bounds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| roadLoad | input | 1 | Write strobe for a road |
| roadSel | input | 6 | Slot index for the write |
| roadWord | input | 22 | Upper bound [21:11], lower bound [10:0] |
| centValid | input | 1 | Centroid present |
| centroid | input | 11 | Centroid position |
| busy | output | 1 | Drain in progress; centroids refused |
| hitValid | output | 1 | `hitWord` carries a hit this cycle |
| hitWord | output | 32 | Index [5:0], centroid [16:6], rest zero |

## Verification
Two functions can fall in the same cycle: a road write and a centroid acceptance. The bench provokes this by writing a slot in the very cycle a centroid is taken, with the new window chosen so that the old and new contents give different hits. The hits emitted must follow the old window. A following centroid must follow the new one. Random traffic also mixes writes with drains and with refused centroids. Every cycle is judged against a behavioural model that keeps the road table in arrays and the pending hits in a queue.

// File: rtl/hitFiltPkg.sv
package hitFiltPkg;
  typedef struct packed {
    logic accept;
    logic draining;
  } ctlStrobe_t;
endpackage

// File: rtl/lowBitEnc.sv
module lowBitEnc #(
  parameter int W  = 31,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (vec[k]) begin
        found = 1'b1;
        idx   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/roadBank.sv
module roadBank
  import hitFiltPkg::*;
#(
  parameter int NUM_ROADS = 46,
  parameter int POS_W     = 11,
  parameter int SEL_W     = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 roadLoad,
  input  logic [SEL_W-1:0]     roadSel,
  input  logic [2*POS_W-1:0]   roadWord,
  input  logic [POS_W-1:0]     centroid,
  input  ctlStrobe_t           strobe,
  output logic [NUM_ROADS-1:0] matchNow,
  output logic [POS_W-1:0]     heldCent
);
  logic [POS_W-1:0]     upperQ [NUM_ROADS];
  logic [POS_W-1:0]     lowerQ [NUM_ROADS];
  logic [NUM_ROADS-1:0] slotValid;

  for (genvar i = 0; i < NUM_ROADS; i++) begin : gSlot
    logic hitSlot;
    assign hitSlot = (roadLoad && roadSel == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) slotValid[i] <= 1'b0;
      else if (hitSlot) slotValid[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hitSlot) begin
        upperQ[i] <= roadWord[2*POS_W-1:POS_W];
        lowerQ[i] <= roadWord[POS_W-1:0];
      end
    end

    assign matchNow[i] = slotValid[i] && (centroid >= lowerQ[i]) && (centroid <= upperQ[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) heldCent <= '0;
    else if (strobe.accept) heldCent <= centroid;
  end

  assert_sel_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (roadLoad && roadSel >= SEL_W'(NUM_ROADS)) |=> $stable(slotValid));

  assert_hold_cent_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.draining && !strobe.accept) |=> $stable(heldCent));
endmodule

// File: rtl/hitScanCtl.sv
module hitScanCtl
  import hitFiltPkg::*;
#(
  parameter int NUM_ROADS = 46,
  parameter int GROUP_A   = 31,
  parameter int IDX_W     = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 centValid,
  input  logic [NUM_ROADS-1:0] matchNow,
  output ctlStrobe_t           strobe,
  output logic                 busy,
  output logic                 hitValid,
  output logic [IDX_W-1:0]     hitIdx
);
  localparam int GROUP_B = NUM_ROADS - GROUP_A;
  localparam int IWA = (GROUP_A > 1) ? $clog2(GROUP_A) : 1;
  localparam int IWB = (GROUP_B > 1) ? $clog2(GROUP_B) : 1;

  typedef enum logic {ST_IDLE, ST_SCAN} scanState_t;
  scanState_t state;
  logic [NUM_ROADS-1:0] pendVec;
  logic [NUM_ROADS-1:0] remainVec;
  logic                 foundA, foundB;
  logic [IWA-1:0]       idxA;
  logic [IWB-1:0]       idxB;
  logic                 accept;

  lowBitEnc #(.W(GROUP_A), .IW(IWA)) u_encA (
    .vec(pendVec[GROUP_A-1:0]), .found(foundA), .idx(idxA));
  lowBitEnc #(.W(GROUP_B), .IW(IWB)) u_encB (
    .vec(pendVec[NUM_ROADS-1:GROUP_A]), .found(foundB), .idx(idxB));

  always_comb begin
    if (foundA) hitIdx = IDX_W'(idxA);
    else        hitIdx = IDX_W'(GROUP_A) + IDX_W'(idxB);
  end

  assign busy     = (state == ST_SCAN);
  assign hitValid = busy && (foundA || foundB);
  assign accept   = (state == ST_IDLE) && centValid;
  assign strobe   = '{accept: accept, draining: busy};

  always_comb begin
    remainVec = pendVec;
    if (hitValid) remainVec[hitIdx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pendVec <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_SCAN;
          pendVec <= matchNow;
        end
        ST_SCAN: begin
          pendVec <= remainVec;
          if (remainVec == '0) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && centValid) |=> busy);

  assert_drain_one_R6: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |=> ($countones(pendVec) == $countones($past(pendVec)) - 1));

  assert_hit_pending_R2: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> (hitIdx < IDX_W'(NUM_ROADS)) && pendVec[hitIdx]);

  assert_ascending_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hitValid && $past(hitValid)) |-> (hitIdx > $past(hitIdx)));
endmodule

// File: rtl/roadHitFilter.sv
module roadHitFilter
  import hitFiltPkg::*;
#(
  parameter int NUM_ROADS = 46,
  parameter int POS_W     = 11,
  parameter int SEL_W     = 6,
  parameter int HIT_W     = 32,
  parameter int GROUP_A   = 31
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               roadLoad,
  input  logic [SEL_W-1:0]   roadSel,
  input  logic [2*POS_W-1:0] roadWord,
  input  logic               centValid,
  input  logic [POS_W-1:0]   centroid,
  output logic               busy,
  output logic               hitValid,
  output logic [HIT_W-1:0]   hitWord
);
  ctlStrobe_t           strobe;
  logic [NUM_ROADS-1:0] matchNow;
  logic [POS_W-1:0]     heldCent;
  logic [SEL_W-1:0]     hitIdx;

  roadBank #(.NUM_ROADS(NUM_ROADS), .POS_W(POS_W), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rstN(rstN), .roadLoad(roadLoad), .roadSel(roadSel),
    .roadWord(roadWord), .centroid(centroid), .strobe(strobe),
    .matchNow(matchNow), .heldCent(heldCent));

  hitScanCtl #(.NUM_ROADS(NUM_ROADS), .GROUP_A(GROUP_A), .IDX_W(SEL_W)) u_ctl (
    .clk(clk), .rstN(rstN), .centValid(centValid), .matchNow(matchNow),
    .strobe(strobe), .busy(busy), .hitValid(hitValid), .hitIdx(hitIdx));

  assign hitWord = HIT_W'({heldCent, hitIdx});

  assert_hit_fields_R5: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> (hitWord[HIT_W-1:POS_W+SEL_W] == '0) && (hitWord[SEL_W-1:0] < SEL_W'(NUM_ROADS)));
endmodule

// File: tb/roadHitFilter_bench.sv
`timescale 1ns/1ps
module roadHitFilter_bench;
  logic        clk = 0;
  logic        rstN = 0;
  logic        roadLoad = 0;
  logic [5:0]  roadSel = 0;
  logic [21:0] roadWord = 0;
  logic        centValid = 0;
  logic [10:0] centroid = 0;
  logic        busy, hitValid;
  logic [31:0] hitWord;

  always #2.5 clk = ~clk;

  roadHitFilter u_roadHitFilter (
    .clk(clk), .rstN(rstN), .roadLoad(roadLoad), .roadSel(roadSel),
    .roadWord(roadWord), .centValid(centValid), .centroid(centroid),
    .busy(busy), .hitValid(hitValid), .hitWord(hitWord));

  int checks = 0, fails = 0, cycles = 0;
  string curReq = "R1";
  bit done = 0;

  int mUp [46];
  int mLo [46];
  bit mVld [46];
  bit mBusy = 0;
  int expQ [$];

  // Reference model: table lookup before the write, queue drained one per cycle
  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; expQ.delete();
      for (int i = 0; i < 46; i++) mVld[i] = 0;
    end else begin
      if (mBusy) begin
        if (expQ.size() > 0) void'(expQ.pop_front());
        if (expQ.size() == 0) mBusy = 0;
      end else if (centValid) begin
        mBusy = 1;
        for (int i = 0; i < 46; i++)
          if (mVld[i] && int'(centroid) >= mLo[i] && int'(centroid) <= mUp[i])
            expQ.push_back((int'(centroid) << 6) | i);
      end
      if (roadLoad && roadSel < 46) begin
        mVld[roadSel] = 1;
        mUp[roadSel] = int'(roadWord[21:11]);
        mLo[roadSel] = int'(roadWord[10:0]);
      end
    end
  end

  always @(negedge clk) begin
    bit eHv; int eW;
    if (!done) begin
      cycles++;
      eHv = mBusy && expQ.size() > 0;
      eW = eHv ? expQ[0] : 0;
      checks++;
      if (busy !== mBusy) begin
        fails++; $display("FAIL %s busy act=%0b exp=%0b t=%0t", curReq, busy, mBusy, $time);
      end
      checks++;
      if (hitValid !== eHv) begin
        fails++; $display("FAIL %s hitValid act=%0b exp=%0b t=%0t", curReq, hitValid, eHv, $time);
      end
      if (eHv) begin
        checks++;
        if (hitWord !== 32'(eW)) begin
          fails++; $display("FAIL %s hitWord act=%h exp=%h t=%0t", curReq, hitWord, eW, $time);
        end
      end
      if (cycles > 100000) begin
        fails++; $display("FAIL watchdog act=%0d exp<=100000", cycles);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    roadLoad = 0; centValid = 0;
  endtask

  task automatic loadRoad(input int sel, input int up, input int lo);
    @(negedge clk);
    roadLoad = 1; roadSel = 6'(sel); roadWord = {11'(up), 11'(lo)};
    @(negedge clk);
    roadLoad = 0;
  endtask

  task automatic sendCent(input int c);
    @(negedge clk);
    while (busy) @(negedge clk);
    centValid = 1; centroid = 11'(c);
    @(negedge clk);
    centValid = 0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    curReq = "R1"; sendCent(100);          // empty table, no hit
    curReq = "R2";
    loadRoad(0, 200, 100);
    loadRoad(5, 150, 150);
    loadRoad(45, 2047, 0);
    loadRoad(31, 190, 180);
    loadRoad(30, 300, 200);
    sendCent(150); sendCent(100); sendCent(200); sendCent(99); sendCent(2047);
    curReq = "R6"; sendCent(185); sendCent(0);
    curReq = "R3";
    loadRoad(10, 400, 500); sendCent(450); sendCent(1);
    curReq = "R5"; loadRoad(44, 2047, 2040); sendCent(2047);
    curReq = "R7"; loadRoad(45, 5, 5); sendCent(6); sendCent(5);
    curReq = "R4";
    loadRoad(46, 2047, 0); loadRoad(63, 2047, 0); sendCent(1000);
    curReq = "R8";
    @(negedge clk);
    centValid = 1; centroid = 11'd150;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); centroid = 11'(k * 37);
    end
    centValid = 0; idle(6);
    curReq = "R9";
    @(negedge clk);
    centValid = 1; centroid = 11'd150;
    roadLoad = 1; roadSel = 6'd5; roadWord = {11'd10, 11'd0};
    @(negedge clk);
    centValid = 0; roadLoad = 0;
    idle(6);
    curReq = "R10"; sendCent(5); sendCent(150);
    curReq = "R6";
    for (int i = 0; i < 46; i++) loadRoad(i, 1500, 500 - i);
    sendCent(1000);
    curReq = "R9";
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      roadLoad  = ($urandom % 3) == 0;
      roadSel   = 6'($urandom % 50);
      roadWord  = {11'($urandom % 2048), 11'($urandom % 2048)};
      centValid = ($urandom % 2) == 0;
      centroid  = 11'($urandom % 2048);
    end
    roadLoad = 0; centValid = 0;
    idle(60);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule